// File: doc/BRIEF.md
# Pulse-Swallow Feedback Frequency Divider

This block divides a fast input clock by a programmable integer modulus and gives one pulse per full divider period. The pulse is meant for the feedback input of a phase-frequency detector. The modulus is built from three settings: a prescaler base ratio N, a main count M and a swallow count A.

The prescaler is a small synchronous counter. It divides by N+1 while the swallow counter is non-zero and by N after that. Two slow counters work at the prescaler rate. The swallow counter is loaded with A at the start of each divider period, so the first A prescaler periods each take one extra input cycle. The main counter closes the divider period after M prescaler periods. The total is therefore M×N+A input cycles, with no single wide programmable counter.

New settings are taken on a load strobe and checked, then held as pending. They move into use only at the next divider-period boundary. A setting that fails the check is refused and raises an error flag.

Top module: `swallow_fb_div`

## Requirements
- R1: The interval between consecutive rising edges of `fb_pulse` is exactly M×N+A input-clock cycles for the configuration in use.
- R2: With A = 0, every prescaler period is N cycles and the divider period is M×N cycles.
- R3: Within each divider period, the first A prescaler periods last N+1 cycles and the remaining M−A last N cycles. `pre_tick` is high during the last input cycle of each prescaler period, and the last one coincides with the last cycle of the divider period.
- R4: `fb_pulse` is high for exactly one input-clock cycle per divider period.
- R5: A configuration accepted by `load` has no effect on the divider period in progress. It governs the period that starts after that one ends.
- R6: A load is refused when any of these holds: N < 2, M = 0, A ≥ M, or M×N+A < 8. On refusal, `cfg_err` is 1 from the next cycle and the previous configuration stays in effect. A valid load clears `cfg_err`.
- R7: During reset, `fb_pulse` and `cfg_err` are 0 and the default configuration is loaded (N=4, M=3, A=1, modulus 13). The first pulse appears one full modulus after reset is released.
- R8: Both ends of the modulus range work exactly: 8 (N=2, M=4, A=0) and 2047 (N=15, M=136, A=7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that samples a new configuration |
| n_in | input | NW (4) | Prescaler base ratio N |
| m_in | input | MW (8) | Main count M |
| a_in | input | AW (8) | Swallow count A |
| fb_pulse | output | 1 | One-cycle pulse at the end of each divider period |
| pre_tick | output | 1 | Prescaler terminal count, high during the last cycle of each prescaler period |
| cfg_err | output | 1 | Last load was refused |

## Verification
`fb_pulse` is registered. It rises at the clock edge that ends the divider period, so the first pulse after reset is seen exactly modulus cycles after release. `pre_tick` is combinational from the counter state, and `cfg_err` is valid one cycle after the load edge.

The bench drives and samples on falling edges. It counts falling edges from one observed pulse to the next, so each measured interval equals the modulus with no offset. Every configuration change is issued just after a pulse and is then allowed one full old period before the new period is measured. This stops a load from landing on a boundary edge.

// File: rtl/swallow_div_pkg.sv
`timescale 1ns/1ps
package swallow_div_pkg;

  // Overall feedback modulus built by the pulse-swallow scheme.
  function automatic int unsigned fb_modulus(int unsigned n, int unsigned m, int unsigned a);
    return m * n + a;
  endfunction

  // Legality of a requested setting.
  function automatic logic cfg_ok(int unsigned n, int unsigned m, int unsigned a,
                                  int unsigned min_mod);
    return (n >= 2) && (m >= 1) && (a < m) && (fb_modulus(n, m, a) >= min_mod);
  endfunction

endpackage

// File: rtl/swd_cfg_regs.sv
`timescale 1ns/1ps
module swd_cfg_regs #(
  parameter int NW      = 4,
  parameter int MW      = 8,
  parameter int AW      = 8,
  parameter int MIN_MOD = 8,
  parameter int DEF_N   = 4,
  parameter int DEF_M   = 3,
  parameter int DEF_A   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] n_in,
  input  logic [MW-1:0] m_in,
  input  logic [AW-1:0] a_in,
  input  logic          apply,
  output logic [NW-1:0] n_pend,
  output logic [MW-1:0] m_pend,
  output logic [AW-1:0] a_pend,
  output logic [NW-1:0] n_act,
  output logic [MW-1:0] m_act,
  output logic [AW-1:0] a_act,
  output logic          cfg_err
);
  import swallow_div_pkg::*;

  logic req_ok;
  assign req_ok = cfg_ok(int'(n_in), int'(m_in), int'(a_in), MIN_MOD);

  // Pending setting: written by an accepted load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_pend  <= NW'(DEF_N);
      m_pend  <= MW'(DEF_M);
      a_pend  <= AW'(DEF_A);
      cfg_err <= 1'b0;
    end else if (load) begin
      if (req_ok) begin
        n_pend  <= n_in;
        m_pend  <= m_in;
        a_pend  <= a_in;
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

  // Active setting: copied from pending only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_act <= NW'(DEF_N);
      m_act <= MW'(DEF_M);
      a_act <= AW'(DEF_A);
    end else if (apply) begin
      n_act <= n_pend;
      m_act <= m_pend;
      a_act <= a_pend;
    end
  end
endmodule

// File: rtl/swd_prescaler.sv
`timescale 1ns/1ps
module swd_prescaler #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_act,
  input  logic          swallow,
  output logic [NW-1:0] pc_cnt,
  output logic          pre_tc
);
  // Last count of this prescaler period: N (divide by N+1) or N-1.
  logic [NW-1:0] last_cnt;
  assign last_cnt = swallow ? n_act : (n_act - NW'(1));
  assign pre_tc   = (pc_cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_cnt <= '0;
    else if (pre_tc) pc_cnt <= '0;
    else             pc_cnt <= pc_cnt + NW'(1);
  end
endmodule

// File: rtl/swd_prog_counters.sv
`timescale 1ns/1ps
module swd_prog_counters #(
  parameter int MW    = 8,
  parameter int AW    = 8,
  parameter int DEF_A = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tc,
  input  logic [MW-1:0] m_act,
  input  logic [AW-1:0] a_pend,
  output logic [MW-1:0] mc_cnt,
  output logic [AW-1:0] a_left,
  output logic          swallow,
  output logic          cyc_end
);
  assign swallow = (a_left != '0);
  assign cyc_end = pre_tc && (mc_cnt == (m_act - MW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_cnt <= '0;
      a_left <= AW'(DEF_A);
    end else if (pre_tc) begin
      if (cyc_end) begin
        mc_cnt <= '0;
        a_left <= a_pend;   // value that becomes active at this edge
      end else begin
        mc_cnt <= mc_cnt + MW'(1);
        if (swallow) a_left <= a_left - AW'(1);
      end
    end
  end
endmodule

// File: rtl/swallow_fb_div.sv
`timescale 1ns/1ps
module swallow_fb_div #(
  parameter int NW      = 4,
  parameter int MW      = 8,
  parameter int AW      = 8,
  parameter int MIN_MOD = 8,
  parameter int DEF_N   = 4,
  parameter int DEF_M   = 3,
  parameter int DEF_A   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] n_in,
  input  logic [MW-1:0] m_in,
  input  logic [AW-1:0] a_in,
  output logic          fb_pulse,
  output logic          pre_tick,
  output logic          cfg_err
);
  // Named internal events, visible to the bound checker.
  logic [NW-1:0] n_pend, n_act, pc_cnt;
  logic [MW-1:0] m_pend, m_act, mc_cnt;
  logic [AW-1:0] a_pend, a_act, a_left;
  logic          pre_tc, swallow, cyc_end;

  swd_cfg_regs #(
    .NW(NW), .MW(MW), .AW(AW), .MIN_MOD(MIN_MOD),
    .DEF_N(DEF_N), .DEF_M(DEF_M), .DEF_A(DEF_A)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .n_in(n_in), .m_in(m_in), .a_in(a_in), .apply(cyc_end),
    .n_pend(n_pend), .m_pend(m_pend), .a_pend(a_pend),
    .n_act(n_act), .m_act(m_act), .a_act(a_act), .cfg_err(cfg_err)
  );

  swd_prescaler #(.NW(NW)) u_pre (
    .clk(clk), .rst_n(rst_n), .n_act(n_act), .swallow(swallow),
    .pc_cnt(pc_cnt), .pre_tc(pre_tc)
  );

  swd_prog_counters #(.MW(MW), .AW(AW), .DEF_A(DEF_A)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc), .m_act(m_act), .a_pend(a_pend),
    .mc_cnt(mc_cnt), .a_left(a_left), .swallow(swallow), .cyc_end(cyc_end)
  );

  assign pre_tick = pre_tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_pulse <= 1'b0;
    else        fb_pulse <= cyc_end;
  end
endmodule

// File: rtl/swallow_fb_div_chk.sv
`timescale 1ns/1ps
module swallow_fb_div_chk #(
  parameter int NW      = 4,
  parameter int MW      = 8,
  parameter int AW      = 8,
  parameter int MIN_MOD = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [NW-1:0] n_in,
  input logic [MW-1:0] m_in,
  input logic [AW-1:0] a_in,
  input logic          fb_pulse,
  input logic          cfg_err,
  input logic          cyc_end,
  input logic          swallow,
  input logic [NW-1:0] pc_cnt,
  input logic [MW-1:0] mc_cnt,
  input logic [NW-1:0] n_act,
  input logic [MW-1:0] m_act,
  input logic [AW-1:0] a_act,
  input logic [NW-1:0] n_pend,
  input logic [MW-1:0] m_pend,
  input logic [AW-1:0] a_pend
);
  import swallow_div_pkg::*;

  p_pulse_follows_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> fb_pulse);

  p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  p_swallow_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swallow |-> (mc_cnt < MW'(a_act)));

  p_prescale_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_cnt <= n_act);

  p_cfg_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> ($stable(n_act) && $stable(m_act) && $stable(a_act)));

  p_bad_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg_ok(int'(n_in), int'(m_in), int'(a_in), MIN_MOD))
      |=> (cfg_err && $stable(n_pend) && $stable(m_pend) && $stable(a_pend)));
endmodule

bind swallow_fb_div swallow_fb_div_chk #(
  .NW(NW), .MW(MW), .AW(AW), .MIN_MOD(MIN_MOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .n_in(n_in), .m_in(m_in), .a_in(a_in),
  .fb_pulse(fb_pulse), .cfg_err(cfg_err), .cyc_end(cyc_end), .swallow(swallow),
  .pc_cnt(pc_cnt), .mc_cnt(mc_cnt), .n_act(n_act), .m_act(m_act), .a_act(a_act),
  .n_pend(n_pend), .m_pend(m_pend), .a_pend(a_pend)
);

// File: tb/swallow_fb_div_bench.sv
`timescale 1ns/1ps
module swallow_fb_div_bench;
  localparam int NW = 4;
  localparam int MW = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [NW-1:0] n_in = '0;
  logic [MW-1:0] m_in = '0;
  logic [AW-1:0] a_in = '0;
  logic          fb_pulse, pre_tick, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  swallow_fb_div u_swallow_fb_div (
    .clk(clk), .rst_n(rst_n), .load(load), .n_in(n_in), .m_in(m_in), .a_in(a_in),
    .fb_pulse(fb_pulse), .pre_tick(pre_tick), .cfg_err(cfg_err)
  );

  function automatic int bench_mod(int n, int m, int a);
    int t = a;
    for (int k = 0; k < m; k++) t += n;
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts falling edges until fb_pulse is seen high.
  task automatic count_to_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!fb_pulse && cnt < 5000);
  endtask

  // Loads at the start of a period and lets the old period finish.
  task automatic set_cfg(int n, int m, int a);
    int c;
    count_to_pulse(c);
    @(negedge clk);
    load = 1'b1; n_in = NW'(n); m_in = MW'(m); a_in = AW'(a);
    @(negedge clk);
    load = 1'b0;
    count_to_pulse(c);
  endtask

  task automatic t_reset();
    int c;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(fb_pulse == 1'b0, "R7 pulse low in reset", fb_pulse, 0);
    check(cfg_err == 1'b0, "R7 err low in reset", cfg_err, 0);
    rst_n = 1'b1;
    count_to_pulse(c);
    check(c == 13, "R7 first pulse", c, 13);
    @(negedge clk);
    check(fb_pulse == 1'b0, "R4 width after first pulse", fb_pulse, 0);
    count_to_pulse(c);
    check(c == 12, "R1 default period (one seen above)", c + 1, 13);
  endtask

  task automatic t_period(int n, int m, int a, string req);
    int c;
    int e = bench_mod(n, m, a);
    set_cfg(n, m, a);
    for (int k = 0; k < 2; k++) begin
      count_to_pulse(c);
      check(c == e, req, c, e);
    end
  endtask

  task automatic t_ticks(int n, int m, int a, string req);
    int bad = 0;
    int nxt;
    int j = 0;
    int e = bench_mod(n, m, a);
    set_cfg(n, m, a);
    nxt = n + ((a > 0) ? 1 : 0) - 1;
    for (int i = 0; i < e; i++) begin
      bit exp_t;
      if (i > 0) @(negedge clk);
      exp_t = (i == nxt);
      if (pre_tick != exp_t) bad++;
      if (exp_t) begin
        j++;
        nxt += n + ((j < a) ? 1 : 0);
      end
    end
    check(bad == 0, req, bad, 0);
    @(negedge clk);
    check(fb_pulse == 1'b1, "R3 last tick ends period", fb_pulse, 1);
  endtask

  task automatic t_width();
    int c;
    count_to_pulse(c);
    @(negedge clk);
    check(fb_pulse == 1'b0, "R4 pulse one cycle", fb_pulse, 0);
  endtask

  task automatic t_midload();
    int c;
    int eo = bench_mod(5, 6, 3);
    int en = bench_mod(7, 4, 2);
    set_cfg(5, 6, 3);
    c = 0;
    repeat (3) begin @(negedge clk); c++; end
    load = 1'b1; n_in = 4'd7; m_in = 8'd4; a_in = 8'd2;
    @(negedge clk); c++;
    load = 1'b0;
    while (!fb_pulse && c < 5000) begin @(negedge clk); c++; end
    check(c == eo, "R5 running period unchanged", c, eo);
    count_to_pulse(c);
    check(c == en, "R5 new setting next period", c, en);
  endtask

  task automatic try_bad(int n, int m, int a, int eo, string req);
    int c;
    count_to_pulse(c);
    @(negedge clk);
    load = 1'b1; n_in = NW'(n); m_in = MW'(m); a_in = AW'(a);
    @(negedge clk);
    load = 1'b0;
    check(cfg_err == 1'b1, req, cfg_err, 1);
    count_to_pulse(c);
    count_to_pulse(c);
    check(c == eo, "R6 old setting kept", c, eo);
  endtask

  task automatic t_errors();
    int eo = bench_mod(4, 5, 0);
    set_cfg(4, 5, 0);
    try_bad(4, 5, 5, eo, "R6 A equal M refused");
    try_bad(1, 9, 0, eo, "R6 N below 2 refused");
    try_bad(2, 3, 1, eo, "R6 modulus 7 refused");
    try_bad(6, 0, 0, eo, "R6 M zero refused");
    set_cfg(3, 4, 1);
    check(cfg_err == 1'b0, "R6 valid load clears flag", cfg_err, 0);
  endtask

  initial begin
    t_reset();
    t_period(5, 6, 3, "R1 period 33");
    t_period(7, 4, 2, "R1 period 30");
    t_period(4, 5, 0, "R2 period 20");
    t_ticks(4, 5, 0, "R2 all prescaler periods N");
    t_ticks(3, 5, 4, "R3 tick positions N=3 A=4");
    t_ticks(6, 3, 2, "R3 tick positions N=6 A=2");
    t_width();
    t_midload();
    t_errors();
    t_period(2, 4, 0, "R8 modulus 8");
    t_period(15, 136, 7, "R8 modulus 2047");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule